// File: doc/BRIEF.md
# Two-Constant Shift-Add Multiplier

This block multiplies a signed input sample by one of two fixed constants without using a multiplier. The product comes from a chain of two adder cells. Every shift in the chain is wiring only, so the cost is two adders and one multiplexer. A single select bit picks the constant each cycle. Changing constants needs no reconfiguration: the multiplexer on the second cell's addend simply flips.

A build-time parameter chooses one of two coefficient pairs.

- **Shared-factor build, {45, 15}.** The first cell forms 5x as x + 4x. The second cell then scales that by 9 or by 3.
- **Subtract build, {45, 23}.** These two constants share no factor. The first cell forms 15x as 16x − x. The second cell adds either 2·(15x), giving 45x, or 8·x taken from the raw input, giving 23x.

The product is registered, so the result appears one clock after the operand and select are presented.

Top module: `dual_const_mult`

## Requirements
- R1: In the shared-factor build (CFG = CFG_SHARED5), alt_sel = 0 gives y = 45·x.
- R2: In the shared-factor build, alt_sel = 1 gives y = 15·x.
- R3: In the subtract build (CFG = CFG_SUB15), alt_sel = 0 gives y = 45·x.
- R4: In the subtract build, alt_sel = 1 gives y = 23·x.
- R5: Timing of the result:
  - x and alt_sel are sampled on the same rising edge.
  - The product of that pair appears on y after exactly one clock.
  - y holds its old value until that edge.
- R6: While rst_n is low at a rising edge, y is cleared to zero on that edge. This holds whatever x and alt_sel are.
- R7: y is N+6 bits wide, two's complement. It holds 45·x exactly at both input extremes, −2^(N−1) and 2^(N−1)−1.
- R8: Sign and zero behaviour:
  - A zero input gives a zero product.
  - A nonzero input gives a product with the same sign as the input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous reset, active low |
| x | input | N | Signed operand |
| alt_sel | input | 1 | 0 selects 45; 1 selects the alternate constant (15 or 23, set by CFG) |
| y | output | N+6 | Registered signed product |

## Verification
Both builds are instantiated at N = 8, and every one of the 256 input codes is applied with each select value. This full sweep exposes any wrong shift amount or wrong addend source, because such a fault changes the product for almost every input. The two extremes −128 and +127 separate a correct N+6-bit result from one that wraps or loses its sign. The select is alternated on consecutive cycles, and y is also observed just before each capturing edge; together these distinguish a correctly registered datapath from one that lags, leads or mixes up the select. A reset applied mid-run with a nonzero operand shows that the output clears rather than captures.

// File: rtl/scm_pkg.sv
// Package: shared configuration type for the two-constant shift-add multiplier.
// Assumes: consumers use the enum to pick the coefficient pair at elaboration time.
package scm_pkg;

    // Which pair of constants the adder chain is wired for.
    typedef enum logic {
        CFG_SHARED5 = 1'b0,   // {45, 15}: common factor of 5
        CFG_SUB15   = 1'b1    // {45, 23}: first cell forms 15x by subtraction
    } chain_cfg_e;

endpackage

// File: rtl/scm_front_cell.sv
// Module: scm_front_cell
// Purpose: first adder cell; forms the shared base multiple of the input
//          (5x in the shared-factor build, 15x in the subtract build).
// Assumes: xw is already sign-extended to W bits, and W has room for 45x.
module scm_front_cell #(
    parameter int                 W   = 22,
    parameter scm_pkg::chain_cfg_e CFG = scm_pkg::CFG_SHARED5
) (
    input  logic signed [W-1:0] xw,
    output logic signed [W-1:0] base
);

    generate
        if (CFG == scm_pkg::CFG_SHARED5) begin : g_add5
            // Base term 5x = x + 4x.
            assign base = xw + (xw <<< 2);
        end else begin : g_sub15
            // Base term 15x = 16x - x.
            assign base = (xw <<< 4) - xw;
        end
    endgenerate

endmodule

// File: rtl/scm_back_cell.sv
// Module: scm_back_cell
// Purpose: second adder cell. It adds a shifted copy of either the base term
//          or the raw input to the base term, chosen by alt_sel.
// Assumes: alt_sel = 0 must yield 45x in both builds.
module scm_back_cell #(
    parameter int                 W   = 22,
    parameter scm_pkg::chain_cfg_e CFG = scm_pkg::CFG_SHARED5
) (
    input  logic signed [W-1:0] xw,
    input  logic signed [W-1:0] base,
    input  logic                alt_sel,
    output logic signed [W-1:0] prod
);

    // Shift amounts for the two addend choices.
    // Shared-factor build: 5x*9 uses <<3, 5x*3 uses <<1.
    // Subtract build: 15x*3 uses <<1, and 23x = 15x + 8x uses <<3 on the raw input.
    localparam int MAIN_SH = (CFG == scm_pkg::CFG_SHARED5) ? 3 : 1;
    localparam int ALT_SH  = (CFG == scm_pkg::CFG_SHARED5) ? 1 : 3;

    logic signed [W-1:0] alt_src;
    logic signed [W-1:0] addend;

    generate
        if (CFG == scm_pkg::CFG_SHARED5) begin : g_alt_base
            // Alternate addend is taken from the base term.
            assign alt_src = base;
        end else begin : g_alt_raw
            // Alternate addend is taken from the raw input.
            assign alt_src = xw;
        end
    endgenerate

    // Addend multiplexer: the only part that differs between the two constants.
    always_comb begin
        addend = alt_sel ? (alt_src <<< ALT_SH) : (base <<< MAIN_SH);
    end

    // Final adder of the chain.
    assign prod = base + addend;

endmodule

// File: rtl/dual_const_mult.sv
// Module: dual_const_mult
// Purpose: y = K*x registered, where K is 45 or an alternate constant (15 or 23),
//          chosen per cycle by alt_sel. Built from two shift-add cells.
// Assumes: synchronous active-low reset; N + 6 <= 32.
module dual_const_mult #(
    parameter int                 N   = 16,
    parameter scm_pkg::chain_cfg_e CFG = scm_pkg::CFG_SHARED5
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic signed [N-1:0]   x,
    input  logic                  alt_sel,
    output logic signed [N+5:0]   y
);

    localparam int GUARD = 6;          // 45 < 2^6
    localparam int W     = N + GUARD;

    logic signed [W-1:0] xw;
    logic signed [W-1:0] base;
    logic signed [W-1:0] prod;

    // Sign-extend the operand to the full product width.
    assign xw = {{GUARD{x[N-1]}}, x};

    scm_front_cell #(.W(W), .CFG(CFG)) u_front (
        .xw   (xw),
        .base (base)
    );

    scm_back_cell #(.W(W), .CFG(CFG)) u_back (
        .xw      (xw),
        .base    (base),
        .alt_sel (alt_sel),
        .prod    (prod)
    );

    // Output register: one cycle of latency, cleared by reset.
    always_ff @(posedge clk) begin
        if (!rst_n) y <= '0;
        else        y <= prod;
    end

endmodule

// File: rtl/dual_const_mult_chk.sv
// Module: dual_const_mult_chk
// Purpose: temporal checks on the ports of dual_const_mult, attached by bind.
// Assumes: the same N and CFG as the bound instance.
module dual_const_mult_chk #(
    parameter int                 N   = 16,
    parameter scm_pkg::chain_cfg_e CFG = scm_pkg::CFG_SHARED5
) (
    input logic                clk,
    input logic                rst_n,
    input logic signed [N-1:0] x,
    input logic                alt_sel,
    input logic signed [N+5:0] y
);

    localparam int K_MAIN = 45;
    localparam int K_ALT  = (CFG == scm_pkg::CFG_SHARED5) ? 15 : 23;

    int xi;

    // Operand widened to an integer for the reference arithmetic.
    assign xi = int'(x);

    AST_MAIN_PRODUCT: assert property (@(posedge clk) disable iff (!rst_n)
        !alt_sel |=> int'(y) == $past(xi) * K_MAIN);          // R1 R3 R5 R7
    AST_ALT_PRODUCT: assert property (@(posedge clk) disable iff (!rst_n)
        alt_sel |=> int'(y) == $past(xi) * K_ALT);            // R2 R4 R5
    AST_RESET_CLEAR: assert property (@(posedge clk)
        !rst_n |=> y == '0);                                  // R6
    AST_ZERO_IN: assert property (@(posedge clk) disable iff (!rst_n)
        x == '0 |=> y == '0);                                 // R8
    AST_SIGN_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        x != '0 |=> y[N+5] == $past(x[N-1]));                 // R8

endmodule

bind dual_const_mult dual_const_mult_chk #(.N(N), .CFG(CFG)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .x       (x),
    .alt_sel (alt_sel),
    .y       (y)
);

// File: tb/dual_const_mult_bench.sv
// Bench: full sweep of both builds at N = 8, with reference products computed here.
module dual_const_mult_bench;

    localparam int N = 8;
    localparam int W = N + 6;

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic signed [N-1:0] x = '0;
    logic                alt_sel = 1'b0;
    logic signed [W-1:0] y_a;
    logic signed [W-1:0] y_b;

    int n_vec = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    // 50 MHz clock.
    always #10 clk = ~clk;

    // Shared-factor build: {45, 15}.
    dual_const_mult #(.N(N), .CFG(scm_pkg::CFG_SHARED5)) u_dual_const_mult (
        .clk(clk), .rst_n(rst_n), .x(x), .alt_sel(alt_sel), .y(y_a)
    );

    // Subtract build: {45, 23}.
    dual_const_mult #(.N(N), .CFG(scm_pkg::CFG_SUB15)) u_dual_const_mult_sub (
        .clk(clk), .rst_n(rst_n), .x(x), .alt_sel(alt_sel), .y(y_b)
    );

    // Count one comparison and report it if it differs.
    task automatic check(input string req, input int act, input int exp);
        n_vec++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Drive one operand at the falling edge, check just before and just after capture.
    task automatic apply(input int xv, input bit s);
        int prev_a;
        int prev_b;
        @(negedge clk);
        prev_a = int'(y_a);
        prev_b = int'(y_b);
        x = N'(xv);
        alt_sel = s;
        #5;
        check("R5 hold before edge (shared)", int'(y_a), prev_a);
        check("R5 hold before edge (sub)", int'(y_b), prev_b);
        @(posedge clk);
        #1;
        if (!s) begin
            check("R1 45x shared-factor", int'(y_a), xv * 45);
            check("R3 45x subtract", int'(y_b), xv * 45);
        end else begin
            check("R2 15x shared-factor", int'(y_a), xv * 15);
            check("R4 23x subtract", int'(y_b), xv * 23);
        end
        if (xv == -(1 <<< (N-1)) || xv == (1 <<< (N-1)) - 1) begin
            check("R7 extreme range shared", int'(y_a), xv * (s ? 15 : 45));
            check("R7 extreme range sub", int'(y_b), xv * (s ? 23 : 45));
        end
        if (xv != 0) begin
            check("R8 sign shared", int'(y_a[W-1]), (xv < 0) ? 1 : 0);
            check("R8 sign sub", int'(y_b[W-1]), (xv < 0) ? 1 : 0);
        end else begin
            check("R8 zero shared", int'(y_a), 0);
            check("R8 zero sub", int'(y_b), 0);
        end
    endtask

    // Main stimulus sequence.
    initial begin
        x = 8'sd77;
        alt_sel = 1'b1;
        repeat (3) @(posedge clk);
        #1;
        check("R6 reset state shared", int'(y_a), 0);
        check("R6 reset state sub", int'(y_b), 0);
        @(negedge clk);
        rst_n = 1'b1;

        // Full sweep, one select value at a time.
        for (int xv = -(1 <<< (N-1)); xv < (1 <<< (N-1)); xv++) apply(xv, 1'b0);
        for (int xv = -(1 <<< (N-1)); xv < (1 <<< (N-1)); xv++) apply(xv, 1'b1);
        // Select toggled every cycle to show it is sampled with its own operand.
        for (int xv = -(1 <<< (N-1)); xv < (1 <<< (N-1)); xv++) apply(xv, xv[0]);

        // Mid-run reset with a live, nonzero operand.
        apply(-100, 1'b0);
        @(negedge clk);
        rst_n = 1'b0;
        x = -8'sd100;
        @(posedge clk);
        #1;
        check("R6 mid-run reset shared", int'(y_a), 0);
        check("R6 mid-run reset sub", int'(y_b), 0);
        @(negedge clk);
        rst_n = 1'b1;
        apply(127, 1'b1);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check and still prints the summary.
    initial begin
        #(20 * 200000);
        if (!done) begin
            n_vec++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

endmodule